// File: doc/BRIEF.md
# PCM Voice-Channel Time-Slot Serial Port

This block moves one 8-bit companded voice code word per frame between parallel ports and a serial time-division-multiplexed highway, in both directions at once. The transmit side takes the word on `tx_word` and sends it most significant bit first during its time slot, with a line-enable flag beside it. The receive side collects eight serial bits into a word register and presents the word on `rx_word`. The surrounding converter and companding logic sit outside this block.

All logic runs on one fast system clock `clk`. The highway clocks, frame syncs and serial input are treated as slow level signals. Each one passes through a single register stage, and edges are found by comparing that stage with its previous value. In fixed-rate mode the master clock `mclk` times both directions. A frame sync one clock period long marks a normal frame. A sync two periods long marks a signaling frame, in which the transmit least significant bit (LSB) is replaced by a signaling input and the received LSB is copied to a signaling output. In variable-rate mode each direction has its own data clock, and its frame sync acts as a time-slot enable. Each direction goes into standby after its frame sync has stayed low for a set number of system clock cycles. While the receive side is in standby it shows the idle code on its parallel output.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset both standby flags are 1. `ser_oe`, `ser_out`, `tx_strobe`, `rx_valid` and `rx_sig` are 0, and `rx_word` shows the idle code.
- R2: In fixed mode (`var_mode`=0), a rising `mclk` edge at which `tx_fs` is high starts a transmit slot. Word bit 7 is driven at that edge, and bits 6 down to 0 follow on the next seven rising edges. `ser_oe` is high for exactly those eight periods and drops at the ninth rising edge. `ser_out` is 0 whenever `ser_oe` is 0.
- R3: In fixed mode `tx_strobe` is high for the same eight periods as the slot. In variable mode it stays 0.
- R4: A fixed-mode frame is a signaling frame when the frame sync is also high at the second rising edge of the slot. In such a frame the transmitted bit 0 is the `tx_sig` value sampled at the slot's first edge. When the sync is high for one edge only, bit 0 is `tx_word[0]`.
- R5: In fixed mode `rx_in` is sampled on the eight falling `mclk` edges that follow the rising edge at which `rx_fs` is high, first bit into bit 7. After the eighth sample, `rx_word` takes the word and `rx_valid` pulses high for one cycle.
- R6: `rx_sig` takes bit 0 of the word received in a signaling frame. A normal frame leaves it unchanged.
- R7: In variable mode (`var_mode`=1) the transmit side shifts on rising `tx_dclk` edges while `tx_fs` is high. The first such edge drives bit 7, and after bit 0 the line holds bit 0. `ser_oe` stays high until `tx_fs` falls. `tx_sig` is never substituted.
- R8: In variable mode the receive side samples on falling `rx_dclk` edges while `rx_fs` is high, and only the first eight samples form the word. `rx_fs` low clears the bit count. Edges that arrive while `rx_fs` is low change nothing.
- R9: A direction enters standby after its own frame sync has been low for `STANDBY_CYCLES` consecutive system clock cycles. The two directions are timed independently.
- R10: While the receive side is in standby, `rx_word` shows the idle code: 8'hFF when `a_law`=0 and 8'hAA when `a_law`=1.
- R11: A frame sync that is high leaves standby at once. The same sync pulse starts a slot in the normal way, so the next word received replaces the idle code.
- R12: Changes on `tx_word` and `tx_sig` after the first edge of a slot have no effect on that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all highway signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| var_mode | input | 1 | 0 = fixed rate on `mclk`, 1 = separate data clocks with slot enables |
| a_law | input | 1 | Selects the A-law idle code (8'hAA) instead of the mu-law one (8'hFF) |
| mclk | input | 1 | Master clock, also the data clock in fixed mode |
| tx_dclk | input | 1 | Transmit data clock in variable mode |
| rx_dclk | input | 1 | Receive data clock in variable mode |
| tx_fs | input | 1 | Transmit frame sync, or slot enable in variable mode |
| rx_fs | input | 1 | Receive frame sync, or slot enable in variable mode |
| tx_word | input | 8 | Code word to send |
| tx_sig | input | 1 | Signaling bit sent as bit 0 in signaling frames |
| rx_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data |
| ser_oe | output | 1 | High while `ser_out` carries slot data |
| tx_strobe | output | 1 | Fixed-mode slot strobe for an external line driver |
| rx_word | output | 8 | Last received word, or the idle code in standby |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is updated |
| rx_sig | output | 1 | Bit 0 of the most recent signaling-frame word |
| tx_standby | output | 1 | Transmit direction in standby |
| rx_standby | output | 1 | Receive direction in standby |

## Verification
On every cycle, the assertions check several timing rules. The serial line changes only on a transmit edge. A fixed-mode slot closes only on a rising edge. A receive word is delivered only just after a falling edge, and never in two back-to-back cycles. `rx_sig` moves only together with a delivered word. Standby is entered only while the frame sync is low and left only when it is high. The bench scenarios cover the rest. They check the bit order on the line and the word captured from it, and the choice of LSB by the length of the sync pulse. They also check that late changes to the parallel inputs are ignored, that the count restarts after a truncated variable-mode slot, that the standby timeout is right, and that the idle code follows `a_law`.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;

  // idle pattern on the parallel receive port
  function automatic code_t quiet_code(input logic a_law);
    code_t q;
    if (a_law) q = code_t'({(CODE_W/2){2'b10}});
    else       q = {CODE_W{1'b1}};
    return q;
  endfunction
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl <= '0;
    else        lvl <= raw;
  end
endmodule

// File: rtl/pcm_idle_timer.sv
module pcm_idle_timer #(
  parameter int LIMIT = 60_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs,
  output logic standby
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      standby <= 1'b1;
      cnt     <= '0;
    end else if (fs) begin
      standby <= 1'b0;
      cnt     <= '0;
    end else if (!standby) begin
      if (cnt == LAST) begin
        standby <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_tx_chan.sv
module pcm_tx_chan
  import pcm_slot_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  var_mode,
  input  logic  dclk_rise,
  input  logic  fs,
  input  code_t word,
  input  logic  sig_in,
  output logic  ser_out,
  output logic  ser_oe,
  output logic  strobe
);
  localparam int CW = $clog2(CODE_W);
  localparam logic [CW-1:0] LAST = CW'(CODE_W - 1);

  logic          active, chk, sigfr, sigbit;
  logic [CW-1:0] cnt;
  code_t         held;
  logic          bit_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      chk    <= 1'b0;
      sigfr  <= 1'b0;
      sigbit <= 1'b0;
      cnt    <= '0;
      held   <= '0;
    end else if (var_mode && !fs) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (dclk_rise) begin
      if (!active) begin
        if (fs) begin
          active <= 1'b1;
          cnt    <= '0;
          held   <= word;
          sigbit <= sig_in;
          sigfr  <= 1'b0;
          chk    <= !var_mode;
        end
      end else begin
        if (chk) begin
          sigfr <= fs;
          chk   <= 1'b0;
        end
        if (cnt != LAST)   cnt    <= cnt + 1'b1;
        else if (!var_mode) active <= 1'b0;
      end
    end
  end

  // the LSB is replaced in a signaling frame
  assign bit_now = (cnt == LAST && sigfr) ? sigbit : held[LAST - cnt];
  assign ser_out = active & bit_now;
  assign ser_oe  = active;
  assign strobe  = active & ~var_mode;
endmodule

// File: rtl/pcm_rx_chan.sv
module pcm_rx_chan
  import pcm_slot_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  var_mode,
  input  logic  dclk_rise,
  input  logic  dclk_fall,
  input  logic  fs,
  input  logic  din,
  output code_t word_q,
  output logic  sig_q,
  output logic  valid
);
  localparam int CW = $clog2(CODE_W);
  localparam logic [CW-1:0] LAST = CW'(CODE_W - 1);

  logic          active, chk, sigfr, done;
  logic [CW-1:0] cnt;
  code_t         shreg, nxt;

  assign nxt = {shreg[CODE_W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      chk    <= 1'b0;
      sigfr  <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      word_q <= '0;
      sig_q  <= 1'b0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (var_mode) begin
        if (!fs) begin
          cnt  <= '0;
          done <= 1'b0;
        end else if (dclk_fall && !done) begin
          shreg <= nxt;
          if (cnt == LAST) begin
            word_q <= nxt;
            valid  <= 1'b1;
            done   <= 1'b1;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else begin
        if (dclk_rise) begin
          if (!active && fs) begin
            active <= 1'b1;
            cnt    <= '0;
            chk    <= 1'b1;
            sigfr  <= 1'b0;
          end else if (active && chk) begin
            sigfr <= fs;
            chk   <= 1'b0;
          end
        end
        if (dclk_fall && active) begin
          shreg <= nxt;
          if (cnt == LAST) begin
            word_q <= nxt;
            valid  <= 1'b1;
            active <= 1'b0;
            if (sigfr) sig_q <= din;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int STANDBY_CYCLES = 60_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              var_mode,
  input  logic              a_law,
  input  logic              mclk,
  input  logic              tx_dclk,
  input  logic              rx_dclk,
  input  logic              tx_fs,
  input  logic              rx_fs,
  input  logic [CODE_W-1:0] tx_word,
  input  logic              tx_sig,
  input  logic              rx_in,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              tx_strobe,
  output logic [CODE_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              rx_sig,
  output logic              tx_standby,
  output logic              rx_standby
);
  localparam int I_MCLK = 0;
  localparam int I_TXD  = 1;
  localparam int I_RXD  = 2;
  localparam int I_TXFS = 3;
  localparam int I_RXFS = 4;
  localparam int I_DIN  = 5;
  localparam int NSYNC  = 6;
  localparam int NCLK   = 3;

  logic [NSYNC-1:0] lvl;
  logic [NCLK-1:0]  clk_d;
  logic mclk_rise, mclk_fall, txd_rise, rxd_fall;
  logic tx_rise_w, rx_fall_w, txfs_lvl, rxfs_lvl;
  code_t rx_word_q;

  pcm_in_sync #(.W(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw({rx_in, rx_fs, tx_fs, rx_dclk, tx_dclk, mclk}),
    .lvl(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_d <= '0;
    else        clk_d <= lvl[NCLK-1:0];
  end

  assign mclk_rise = lvl[I_MCLK] & ~clk_d[I_MCLK];
  assign mclk_fall = ~lvl[I_MCLK] & clk_d[I_MCLK];
  assign txd_rise  = lvl[I_TXD] & ~clk_d[I_TXD];
  assign rxd_fall  = ~lvl[I_RXD] & clk_d[I_RXD];
  assign tx_rise_w = var_mode ? txd_rise : mclk_rise;
  assign rx_fall_w = var_mode ? rxd_fall : mclk_fall;
  assign txfs_lvl  = lvl[I_TXFS];
  assign rxfs_lvl  = lvl[I_RXFS];

  pcm_tx_chan u_tx (
    .clk(clk), .rst_n(rst_n), .var_mode(var_mode),
    .dclk_rise(tx_rise_w), .fs(txfs_lvl),
    .word(tx_word), .sig_in(tx_sig),
    .ser_out(ser_out), .ser_oe(ser_oe), .strobe(tx_strobe)
  );

  pcm_rx_chan u_rx (
    .clk(clk), .rst_n(rst_n), .var_mode(var_mode),
    .dclk_rise(mclk_rise), .dclk_fall(rx_fall_w),
    .fs(rxfs_lvl), .din(lvl[I_DIN]),
    .word_q(rx_word_q), .sig_q(rx_sig), .valid(rx_valid)
  );

  pcm_idle_timer #(.LIMIT(STANDBY_CYCLES)) u_tx_idle (
    .clk(clk), .rst_n(rst_n), .fs(txfs_lvl), .standby(tx_standby)
  );

  pcm_idle_timer #(.LIMIT(STANDBY_CYCLES)) u_rx_idle (
    .clk(clk), .rst_n(rst_n), .fs(rxfs_lvl), .standby(rx_standby)
  );

  assign rx_word = rx_standby ? quiet_code(a_law) : rx_word_q;
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk (
  input logic clk,
  input logic rst_n,
  input logic var_mode,
  input logic ser_out,
  input logic ser_oe,
  input logic rx_valid,
  input logic rx_sig,
  input logic tx_standby,
  input logic rx_standby,
  input logic tx_rise_w,
  input logic rx_fall_w,
  input logic txfs_lvl,
  input logic rxfs_lvl
);
  AST_SER_HOLDS_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && !tx_rise_w) |=> (!ser_oe || $stable(ser_out))); // R2

  AST_FIXED_SLOT_ENDS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ser_oe) && !var_mode) |-> $past(tx_rise_w)); // R2

  AST_RX_WORD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_fall_w)); // R5

  AST_RX_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R5

  AST_RXSIG_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_sig) |-> rx_valid); // R6

  AST_TX_STANDBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_standby) |-> $past(!txfs_lvl)); // R9

  AST_RX_STANDBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_standby) |-> $past(!rxfs_lvl)); // R9

  AST_RX_STANDBY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_standby) |-> $past(rxfs_lvl)); // R11

  AST_TX_STANDBY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_standby) |-> $past(txfs_lvl)); // R11
endmodule

bind pcm_slot_port pcm_slot_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .var_mode(var_mode),
  .ser_out(ser_out), .ser_oe(ser_oe),
  .rx_valid(rx_valid), .rx_sig(rx_sig),
  .tx_standby(tx_standby), .rx_standby(rx_standby),
  .tx_rise_w(tx_rise_w), .rx_fall_w(rx_fall_w),
  .txfs_lvl(txfs_lvl), .rxfs_lvl(rxfs_lvl)
);

// File: tb/pcm_slot_port_bench.sv
`timescale 1ns/1ps
module pcm_slot_port_bench;
  localparam int STBY = 400;
  localparam int HP   = 8;

  logic clk = 1'b0;
  logic rst_n, var_mode, a_law, mclk, tx_dclk, rx_dclk, tx_fs, rx_fs, tx_sig, rx_in;
  logic [7:0] tx_word, rx_word;
  logic ser_out, ser_oe, tx_strobe, rx_valid, rx_sig, tx_standby, rx_standby;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pcm_slot_port #(.STANDBY_CYCLES(STBY)) u_pcm_slot_port (
    .clk(clk), .rst_n(rst_n), .var_mode(var_mode), .a_law(a_law),
    .mclk(mclk), .tx_dclk(tx_dclk), .rx_dclk(rx_dclk),
    .tx_fs(tx_fs), .rx_fs(rx_fs), .tx_word(tx_word), .tx_sig(tx_sig),
    .rx_in(rx_in), .ser_out(ser_out), .ser_oe(ser_oe), .tx_strobe(tx_strobe),
    .rx_word(rx_word), .rx_valid(rx_valid), .rx_sig(rx_sig),
    .tx_standby(tx_standby), .rx_standby(rx_standby)
  );

  always @(posedge clk) if (rst_n && rx_valid) vcount++;

  // {sigframe, tx_sig, tx_word, rx bits, expected line word, expected rx_sig}
  localparam logic [26:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C, 8'hA5, 1'b0},
    {1'b1, 1'b0, 8'h81, 8'hC3, 8'h80, 1'b1},
    {1'b0, 1'b1, 8'h7E, 8'h5A, 8'h7E, 1'b1},
    {1'b1, 1'b1, 8'h00, 8'h00, 8'h01, 1'b0},
    {1'b1, 1'b0, 8'hFF, 8'h01, 8'hFE, 1'b1},
    {1'b0, 1'b0, 8'h0F, 8'hF0, 8'h0F, 1'b1}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic ok,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (ok !== 1'b1) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // fixed-rate frame, transmit and receive in the same slot
  task automatic fixed_frame(input logic sigfr, input logic txs, input logic [7:0] txw,
                             input logic [7:0] rxb, input logic [7:0] exp_ser,
                             input logic exp_sig);
    logic [7:0] got;
    int v0;
    v0 = vcount;
    got = '0;
    tx_word = txw; tx_sig = txs; tx_fs = 1; rx_fs = 1;
    wait_clk(HP);
    for (int k = 0; k < 9; k++) begin
      mclk = 1;
      if (k < 8) rx_in = rxb[7-k];
      wait_clk(HP/2);
      if (k == 0) begin
        tx_fs = sigfr; rx_fs = sigfr;
        tx_word = ~txw; tx_sig = ~txs;   // R12: late changes
      end else if (k == 1) begin
        tx_fs = 0; rx_fs = 0;
      end
      if (k < 8) begin
        got[7-k] = ser_out;
        check("R3 slot strobe/enable", {ser_oe, tx_strobe} === 2'b11, {ser_oe, tx_strobe}, 2'b11);
      end else begin
        check("R2 slot closes", {ser_oe, tx_strobe, ser_out} === 3'b000,
              {ser_oe, tx_strobe, ser_out}, 3'b000);
      end
      wait_clk(HP/2);
      mclk = 0;
      wait_clk(HP);
    end
    check("R2 R4 R12 line word", got === exp_ser, got, exp_ser);
    check("R5 rx word", rx_word === rxb, rx_word, rxb);
    check("R5 one valid pulse", vcount == v0 + 1, vcount - v0, 1);
    check("R6 rx_sig", rx_sig === exp_sig, rx_sig, exp_sig);
  endtask

  // variable-rate slot with 10 data-clock periods
  task automatic var_frame(input logic [7:0] txw, input logic [7:0] rxb);
    logic [7:0] prev_word;
    int v0;
    v0 = vcount;
    tx_word = txw; tx_sig = ~txw[0]; tx_fs = 1; rx_fs = 1;
    wait_clk(HP);
    for (int k = 0; k < 10; k++) begin
      logic expb;
      tx_dclk = 1; rx_dclk = 1;
      rx_in = (k < 8) ? rxb[7-k] : ~rxb[0];
      wait_clk(HP/2);
      if (k == 0) tx_word = ~txw;
      expb = (k < 8) ? txw[7-k] : txw[0];
      check("R7 variable line bit", ser_out === expb && ser_oe === 1'b1, {ser_oe, ser_out}, {1'b1, expb});
      check("R3 no strobe in variable mode", tx_strobe === 1'b0, tx_strobe, 0);
      wait_clk(HP/2);
      tx_dclk = 0; rx_dclk = 0;
      wait_clk(HP);
    end
    tx_fs = 0; rx_fs = 0;
    wait_clk(HP);
    check("R7 enable low closes slot", ser_oe === 1'b0, ser_oe, 0);
    check("R8 variable rx word", rx_word === rxb, rx_word, rxb);
    check("R8 one valid pulse", vcount == v0 + 1, vcount - v0, 1);
    prev_word = rx_word;
    // R8: edges with enable low are ignored
    for (int k = 0; k < 8; k++) begin
      rx_in = 1; tx_dclk = 1; rx_dclk = 1; wait_clk(HP);
      rx_in = 0; tx_dclk = 0; rx_dclk = 0; wait_clk(HP);
    end
    check("R8 edges ignored while enable low", rx_word === prev_word && vcount == v0 + 1,
          rx_word, prev_word);
    check("R7 line idle while enable low", ser_oe === 1'b0 && ser_out === 1'b0, ser_oe, 0);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    rst_n = 0; var_mode = 0; a_law = 0; mclk = 0; tx_dclk = 0; rx_dclk = 0;
    tx_fs = 0; rx_fs = 0; tx_sig = 0; rx_in = 0; tx_word = '0;
    wait_clk(5);
    rst_n = 1;
    wait_clk(2);
    // R1 reset state
    check("R1 standby flags", {tx_standby, rx_standby} === 2'b11, {tx_standby, rx_standby}, 2'b11);
    check("R1 line idle", {ser_oe, ser_out, tx_strobe} === 3'b000, {ser_oe, ser_out, tx_strobe}, 0);
    check("R1 rx outputs", {rx_valid, rx_sig} === 2'b00, {rx_valid, rx_sig}, 0);
    check("R10 mu-law idle code", rx_word === 8'hFF, rx_word, 8'hFF);
    a_law = 1; wait_clk(1);
    check("R10 A-law idle code", rx_word === 8'hAA, rx_word, 8'hAA);
    a_law = 0; wait_clk(1);

    // table: fixed-rate frames (first one also wakes from standby, R11)
    foreach (VEC[i]) begin
      logic [26:0] v;
      v = VEC[i];
      fixed_frame(v[26], v[25], v[24:17], v[16:9], v[8:1], v[0]);
      if (i == 0) check("R11 awake after frame", rx_standby === 1'b0, rx_standby, 0);
    end

    // R9 standby timing and independence
    tx_fs = 1; rx_fs = 1; wait_clk(4);
    tx_fs = 0; rx_fs = 0;
    wait_clk(STBY - 50);
    check("R9 not yet in standby", {tx_standby, rx_standby} === 2'b00, {tx_standby, rx_standby}, 0);
    wait_clk(100);
    check("R9 standby entered", {tx_standby, rx_standby} === 2'b11, {tx_standby, rx_standby}, 2'b11);
    check("R10 idle code in standby", rx_word === 8'hFF, rx_word, 8'hFF);
    a_law = 1; wait_clk(1);
    check("R10 A-law idle code in standby", rx_word === 8'hAA, rx_word, 8'hAA);
    a_law = 0;
    tx_fs = 1; wait_clk(4); tx_fs = 0; wait_clk(4);
    check("R9 directions independent", {tx_standby, rx_standby} === 2'b01,
          {tx_standby, rx_standby}, 2'b01);
    check("R10 rx still idle code", rx_word === 8'hFF, rx_word, 8'hFF);

    // R11 wake with a real frame
    fixed_frame(1'b0, 1'b0, 8'h12, 8'h96, 8'h12, 1'b1);
    check("R11 woken and word delivered", rx_standby === 1'b0 && rx_word === 8'h96, rx_word, 8'h96);

    // variable-rate mode
    var_mode = 1; wait_clk(4);
    var_frame(8'hC6, 8'h5B);
    // R8: truncated slot then full slot
    rx_fs = 1; wait_clk(HP);
    for (int k = 0; k < 3; k++) begin
      rx_in = 1; rx_dclk = 1; wait_clk(HP);
      rx_dclk = 0; wait_clk(HP);
    end
    rx_fs = 0; wait_clk(HP);
    var_frame(8'h39, 8'h3C);

    finish_sim();
  end
endmodule